// File: doc/BRIEF.md
# Two-Level Segment/Page Table Walker

This block resolves a 24-bit virtual address to a physical address when the translation cache has no entry for it. It reads a segment table entry in memory, then a page table entry, and returns the physical frame joined to the untranslated byte offset. If either entry is not valid, it reports a fault. The fault report says whether the walk stopped at the segment level or at the page level.

The walker also maintains the status bits in the page table entry. A completed access sets the referenced bit. A store access also sets the dirty bit. When either bit changes, the walker writes the updated entry back to memory before it reports the result. All table traffic uses one word-wide port. Each request on that port is held until the memory answers with a response pulse.

A new translation request is taken only while the walker is idle. The caller provides the segment table base with the request. A successful result can then be loaded into the translation cache by the caller.

Top module: `seg_page_walker`

## Requirements
- R1: The virtual address is split as segment index = bits [23:20], page index = bits [19:12] and byte offset = bits [11:0]. The segment entry is read from the word at byte address `seg_base + 4*segment index`. A segment entry has bit 31 as its valid flag and bits [23:0] as the byte address of its page table.
- R2: If the segment entry's valid flag is clear, the walk ends with `resp_fault`=1 and `resp_fault_page`=0. No page table entry is read and nothing is written.
- R3: The page entry is read from byte address `page table base + 4*page index`. In a page entry, bit 31 is valid, bit 30 is referenced, bit 29 is dirty and bits [11:0] are the frame number.
- R4: If the page entry's valid flag is clear, the walk ends with `resp_fault`=1 and `resp_fault_page`=1. The entry in memory is not written.
- R5: A successful walk reports `resp_fault`=0 and `resp_pa` = {frame number, byte offset}.
- R6: A load access to a valid page whose referenced bit is clear writes the entry back with bit 30 set. All other bits of the entry are kept unchanged.
- R7: A store access to a valid page whose dirty bit is clear writes the entry back with both bit 30 and bit 29 set.
- R8: When the referenced bit (and, for a store, the dirty bit) is already set, no write is issued. A walk then makes exactly two reads.
- R9: `req_ready` is high only while idle. A `req_valid` pulse during a walk is ignored: it produces no extra walk and no extra response.
- R10: A memory request keeps its address and kind stable until `mem_rsp_valid`. The result appears as a single-cycle `resp_valid` pulse, after which the walker is ready again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_base | input | 24 | Segment table base byte address, sampled with the request |
| req_valid | input | 1 | Translation request |
| req_va | input | 24 | Virtual address to translate |
| req_write | input | 1 | 1 = store access, 0 = load access |
| req_ready | output | 1 | Walker idle, request will be taken |
| mem_req_valid | output | 1 | Memory request active |
| mem_req_write | output | 1 | 1 = write of `mem_req_wdata`, 0 = read |
| mem_req_addr | output | 24 | Word-aligned byte address |
| mem_req_wdata | output | 32 | Updated page entry for write-back |
| mem_rsp_valid | input | 1 | One-cycle completion of the active memory request |
| mem_rsp_rdata | input | 32 | Read data, valid with `mem_rsp_valid` |
| resp_valid | output | 1 | One-cycle result pulse |
| resp_fault | output | 1 | Walk ended in a fault |
| resp_fault_page | output | 1 | With a fault: 1 = page level, 0 = segment level |
| resp_pa | output | 24 | Physical address, meaningful without a fault |

## Verification
The bench targets the write-back corners. Load and store walks run against entries whose status bits are already set and entries where they are clear. A walker that always wrote back, or never did, would show the wrong write count. One that rebuilt the entry instead of setting bits would corrupt the neighbouring entry bits, and the bench checks those in memory. Faults at both levels are checked, along with the read count: a segment fault that still fetched a page entry, or a page fault that wrote the entry, is caught. The highest segment and page indices with an all-ones offset check that the address fields are split correctly. A request pulsed mid-walk would show up as a second response if it were not ignored.

// File: rtl/swalk_pkg.sv
// Shared types and entry bit positions for the segment/page table walker.
// Assumes 32-bit table entries with status flags in the top three bits.
package swalk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEG,
        ST_PTE,
        ST_WB,
        ST_DONE,
        ST_FAULT
    } walk_state_t;

    localparam int ENT_V_BIT = 31;
    localparam int ENT_R_BIT = 30;
    localparam int ENT_W_BIT = 29;

    localparam logic FLT_SEG  = 1'b0;
    localparam logic FLT_PAGE = 1'b1;
endpackage

// File: rtl/swalk_decode.sv
// Decodes a table word read from memory: valid flag, next-level base, and
// the page entry with its status bits updated for the current access.
// Assumes ADDR_W <= 29 so the base field does not overlap the flag bits.
module swalk_decode
    import swalk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 24
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic              wr_access,
    output logic              ent_valid,
    output logic [ADDR_W-1:0] ent_base,
    output logic              need_wb,
    output logic [DATA_W-1:0] wb_data
);
    // Field extraction and status-bit update of the incoming entry.
    always_comb begin
        ent_valid          = rdata[ENT_V_BIT];
        ent_base           = rdata[ADDR_W-1:0];
        wb_data            = rdata;
        wb_data[ENT_R_BIT] = 1'b1;
        if (wr_access) begin
            wb_data[ENT_W_BIT] = 1'b1;
        end
        need_wb = (wb_data != rdata);
    end
endmodule

// File: rtl/swalk_addr.sv
// Forms the word-aligned byte address of the memory access for the current
// walk state: segment entry in ST_SEG, page entry otherwise.
// Assumes each entry occupies DATA_W/8 bytes.
module swalk_addr
    import swalk_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int SEG_W  = 4,
    parameter int PAGE_W = 8
) (
    input  walk_state_t       state,
    input  logic [ADDR_W-1:0] seg_tbl,
    input  logic [ADDR_W-1:0] page_tbl,
    input  logic [SEG_W-1:0]  seg_idx,
    input  logic [PAGE_W-1:0] page_idx,
    output logic [ADDR_W-1:0] addr
);
    localparam int WORD_SH = $clog2(DATA_W / 8);

    // Table base plus scaled index for the level being read.
    always_comb begin
        if (state == ST_SEG) begin
            addr = seg_tbl + (ADDR_W'(seg_idx) << WORD_SH);
        end else begin
            addr = page_tbl + (ADDR_W'(page_idx) << WORD_SH);
        end
    end
endmodule

// File: rtl/swalk_fsm.sv
// Walk controller: takes a request in idle, reads the segment entry, then
// the page entry, optionally writes the entry back, and ends in DONE or
// FAULT for exactly one cycle. Each memory state waits for mem_rsp_valid.
module swalk_fsm
    import swalk_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int VA_W    = 24,
    parameter int DATA_W  = 32,
    parameter int FRAME_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_va,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  seg_base,
    input  logic               mem_rsp_valid,
    input  logic               ent_valid,
    input  logic [ADDR_W-1:0]  ent_base,
    input  logic               need_wb,
    input  logic [DATA_W-1:0]  wb_data,
    input  logic [FRAME_W-1:0] rsp_frame,
    output walk_state_t        state,
    output logic [VA_W-1:0]    va_q,
    output logic               wr_q,
    output logic [ADDR_W-1:0]  base_q,
    output logic [ADDR_W-1:0]  ptb_q,
    output logic [FRAME_W-1:0] frame_q,
    output logic [DATA_W-1:0]  wb_q,
    output logic               level_q
);
    // State sequencing and capture of request, table base and entry fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            va_q    <= '0;
            wr_q    <= 1'b0;
            base_q  <= '0;
            ptb_q   <= '0;
            frame_q <= '0;
            wb_q    <= '0;
            level_q <= FLT_SEG;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_va;
                        wr_q   <= req_write;
                        base_q <= seg_base;
                        state  <= ST_SEG;
                    end
                end
                ST_SEG: begin
                    if (mem_rsp_valid) begin
                        if (ent_valid) begin
                            ptb_q <= ent_base;
                            state <= ST_PTE;
                        end else begin
                            level_q <= FLT_SEG;
                            state   <= ST_FAULT;
                        end
                    end
                end
                ST_PTE: begin
                    if (mem_rsp_valid) begin
                        frame_q <= rsp_frame;
                        wb_q    <= wb_data;
                        if (!ent_valid) begin
                            level_q <= FLT_PAGE;
                            state   <= ST_FAULT;
                        end else if (need_wb) begin
                            state <= ST_WB;
                        end else begin
                            state <= ST_DONE;
                        end
                    end
                end
                ST_WB: begin
                    if (mem_rsp_valid) begin
                        state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2
    seg_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEG && mem_rsp_valid && !ent_valid)
        |=> (state == ST_FAULT && level_q == FLT_SEG));

    // R7
    store_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WB && wr_q) |-> wb_q[ENT_W_BIT]);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(va_q) && $stable(wr_q)));
endmodule

// File: rtl/seg_page_walker.sv
// Top of the two-level segment/page table walker. Wires the controller,
// the entry decoder and the address former, and drives the memory port and
// result outputs from the registered walk state.
// Assumes one outstanding memory request, completed by a mem_rsp_valid pulse.
module seg_page_walker
    import swalk_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int DATA_W  = 32,
    parameter int SEG_W   = 4,
    parameter int PAGE_W  = 8,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        seg_base,
    input  logic                     req_valid,
    input  logic [SEG_W+PAGE_W+OFF_W-1:0] req_va,
    input  logic                     req_write,
    output logic                     req_ready,
    output logic                     mem_req_valid,
    output logic                     mem_req_write,
    output logic [ADDR_W-1:0]        mem_req_addr,
    output logic [DATA_W-1:0]        mem_req_wdata,
    input  logic                     mem_rsp_valid,
    input  logic [DATA_W-1:0]        mem_rsp_rdata,
    output logic                     resp_valid,
    output logic                     resp_fault,
    output logic                     resp_fault_page,
    output logic [FRAME_W+OFF_W-1:0] resp_pa
);
    localparam int VA_W = SEG_W + PAGE_W + OFF_W;
    localparam int PA_W = FRAME_W + OFF_W;

    walk_state_t        state;
    logic [VA_W-1:0]    va_q;
    logic               wr_q;
    logic [ADDR_W-1:0]  base_q;
    logic [ADDR_W-1:0]  ptb_q;
    logic [FRAME_W-1:0] frame_q;
    logic [DATA_W-1:0]  wb_q;
    logic               level_q;
    logic               ent_valid;
    logic [ADDR_W-1:0]  ent_base;
    logic               need_wb;
    logic [DATA_W-1:0]  wb_data;

    swalk_fsm #(
        .ADDR_W (ADDR_W),
        .VA_W   (VA_W),
        .DATA_W (DATA_W),
        .FRAME_W(FRAME_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_va       (req_va),
        .req_write    (req_write),
        .seg_base     (seg_base),
        .mem_rsp_valid(mem_rsp_valid),
        .ent_valid    (ent_valid),
        .ent_base     (ent_base),
        .need_wb      (need_wb),
        .wb_data      (wb_data),
        .rsp_frame    (mem_rsp_rdata[FRAME_W-1:0]),
        .state        (state),
        .va_q         (va_q),
        .wr_q         (wr_q),
        .base_q       (base_q),
        .ptb_q        (ptb_q),
        .frame_q      (frame_q),
        .wb_q         (wb_q),
        .level_q      (level_q)
    );

    swalk_decode #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_decode (
        .rdata    (mem_rsp_rdata),
        .wr_access(wr_q),
        .ent_valid(ent_valid),
        .ent_base (ent_base),
        .need_wb  (need_wb),
        .wb_data  (wb_data)
    );

    swalk_addr #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .SEG_W (SEG_W),
        .PAGE_W(PAGE_W)
    ) u_addr (
        .state   (state),
        .seg_tbl (base_q),
        .page_tbl(ptb_q),
        .seg_idx (va_q[VA_W-1 -: SEG_W]),
        .page_idx(va_q[OFF_W +: PAGE_W]),
        .addr    (mem_req_addr)
    );

    // Port-level decode of the walk state.
    always_comb begin
        req_ready       = (state == ST_IDLE);
        mem_req_valid   = (state == ST_SEG) || (state == ST_PTE) || (state == ST_WB);
        mem_req_write   = (state == ST_WB);
        mem_req_wdata   = wb_q;
        resp_valid      = (state == ST_DONE) || (state == ST_FAULT);
        resp_fault      = (state == ST_FAULT);
        resp_fault_page = (state == ST_FAULT) && (level_q == FLT_PAGE);
        resp_pa         = PA_W'({frame_q, va_q[OFF_W-1:0]});
    end

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid)
        |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    // R10
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && req_ready));

    // R6
    wb_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write)
        |-> (mem_req_wdata[ENT_V_BIT] && mem_req_wdata[ENT_R_BIT]));

    // R9
    busy_noready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || resp_valid) |-> !req_ready);
endmodule

// File: tb/test_seg_page_walker.sv
module test_seg_page_walker;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 2048;
    localparam logic [23:0] SB = 24'h000100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] seg_base = SB;
    logic        req_valid = 1'b0;
    logic [23:0] req_va = '0;
    logic        req_write = 1'b0;
    logic        req_ready;
    logic        mem_req_valid, mem_req_write;
    logic [23:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        resp_valid, resp_fault, resp_fault_page;
    logic [23:0] resp_pa;

    seg_page_walker i_seg_page_walker (
        .clk(clk), .rst_n(rst_n), .seg_base(seg_base),
        .req_valid(req_valid), .req_va(req_va), .req_write(req_write),
        .req_ready(req_ready),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .resp_valid(resp_valid), .resp_fault(resp_fault),
        .resp_fault_page(resp_fault_page), .resp_pa(resp_pa)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] mem [MEM_WORDS];
    int lat = 0;
    int wait_cnt = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;

    typedef struct {
        string       tag;
        logic        fault;
        logic        fpage;
        logic [23:0] pa;
        int          n_rd;
        int          n_wr;
        logic        chk_mem;
        int          mem_idx;
        logic [31:0] mem_exp;
    } exp_t;
    exp_t sb_q[$];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model: answers the held request after lat idle cycles.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rsp_valid = 1'b0;
            wait_cnt = 0;
        end else if (mem_rsp_valid) begin
            mem_rsp_valid = 1'b0;
        end else if (mem_req_valid) begin
            if (wait_cnt < lat) begin
                wait_cnt++;
            end else begin
                int idx;
                wait_cnt = 0;
                idx = int'(mem_req_addr >> 2) % MEM_WORDS;
                if (mem_req_write) begin
                    mem[idx] = mem_req_wdata;
                    wr_cnt++;
                end else begin
                    mem_rsp_rdata = mem[idx];
                    rd_cnt++;
                end
                mem_rsp_valid = 1'b1;
            end
        end
    end

    // Scoreboard monitor: compares each result pulse with the queued item.
    int last_rd = 0;
    int last_wr = 0;
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (sb_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R9 unexpected response actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " fault"}, 32'(resp_fault), 32'(e.fault));
                if (e.fault) begin
                    check({e.tag, " fault level"}, 32'(resp_fault_page), 32'(e.fpage));
                end else begin
                    check({e.tag, " pa"}, 32'(resp_pa), 32'(e.pa));
                end
                check({e.tag, " reads"}, 32'(rd_cnt - last_rd), 32'(e.n_rd));
                check({e.tag, " writes"}, 32'(wr_cnt - last_wr), 32'(e.n_wr));
                if (e.chk_mem) begin
                    check({e.tag, " entry in memory"}, mem[e.mem_idx], e.mem_exp);
                end
            end
            last_rd = rd_cnt;
            last_wr = wr_cnt;
        end
    end

    // Driver: predicts the result from the bench's tables, queues it, drives.
    task automatic walk(string tag, logic [3:0] seg, logic [7:0] pg,
                        logic [11:0] off, logic wr);
        exp_t e;
        logic [31:0] ste, pte, upd;
        int pidx;
        e.tag = tag; e.fault = 0; e.fpage = 0; e.pa = '0;
        e.n_rd = 1; e.n_wr = 0; e.chk_mem = 0; e.mem_idx = 0; e.mem_exp = '0;
        ste = mem[int'((SB + 24'(seg) * 4) >> 2)];
        if (!ste[31]) begin
            e.fault = 1; e.fpage = 0;
        end else begin
            pidx = int'((ste[23:0] + 24'(pg) * 4) >> 2);
            pte = mem[pidx];
            e.n_rd = 2;
            e.chk_mem = 1;
            e.mem_idx = pidx;
            if (!pte[31]) begin
                e.fault = 1; e.fpage = 1; e.mem_exp = pte;
            end else begin
                upd = pte | 32'h4000_0000 | (wr ? 32'h2000_0000 : 32'h0);
                e.n_wr = (upd != pte) ? 1 : 0;
                e.mem_exp = upd;
                e.pa = {pte[11:0], off};
            end
        end
        sb_q.push_back(e);
        while (!req_ready) @(negedge clk);
        req_va = {seg, pg, off};
        req_write = wr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
        mem[(SB >> 2) + 0]  = 32'h8000_0400;
        mem[(SB >> 2) + 15] = 32'h8000_0800;
        mem[(SB >> 2) + 5]  = 32'h8000_0C00;
        mem[(SB >> 2) + 3]  = 32'h0000_0400;
        mem[(24'h400 >> 2) + 1]   = 32'h8155_0ABC;
        mem[(24'h400 >> 2) + 2]   = 32'h4000_0123;
        mem[(24'h800 >> 2) + 255] = 32'hC000_0FFF;
        mem[(24'hC00 >> 2) + 0]   = 32'hE000_0001;

        repeat (3) @(negedge clk);
        check("R10 reset req_ready", 32'(req_ready), 32'd1);
        check("R10 reset resp_valid", 32'(resp_valid), 32'd0);
        check("R10 reset mem_req_valid", 32'(mem_req_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        lat = 0;
        walk("R5 R6 load sets referenced", 4'd0, 8'd1, 12'h123, 1'b0);
        drain();
        check("R10 result is one pulse", 32'(resp_valid), 32'd0);
        walk("R8 load no write-back", 4'd0, 8'd1, 12'h456, 1'b0);
        drain();
        lat = 3;
        walk("R7 store sets dirty", 4'd0, 8'd1, 12'h010, 1'b1);
        drain();
        walk("R8 store no write-back", 4'd0, 8'd1, 12'h020, 1'b1);
        drain();
        walk("R2 segment fault", 4'd3, 8'd1, 12'h000, 1'b0);
        drain();
        lat = 1;
        walk("R4 page fault", 4'd0, 8'd2, 12'h000, 1'b1);
        drain();
        walk("R1 R3 top indices store", 4'd15, 8'd255, 12'hFFF, 1'b1);
        drain();
        lat = 2;
        walk("R8 R5 all bits set", 4'd5, 8'd0, 12'h000, 1'b1);
        drain();

        // R9: a request pulsed mid-walk must be ignored.
        lat = 4;
        walk("R9 busy first request", 4'd15, 8'd255, 12'h321, 1'b0);
        @(negedge clk);
        check("R9 busy ready low", 32'(req_ready), 32'd0);
        req_va = {4'd3, 8'd0, 12'h000};
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        drain();
        repeat (20) @(negedge clk);
        check("R9 no second walk", 32'(sb_q.size()), 32'd0);
        check("R9 idle after walk", 32'(req_ready), 32'd1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule